// File: doc/BRIEF.md
# Modular Adder/Subtractor over a Prime Modulus

This block adds or subtracts two operands modulo a prime `p` supplied on its own port. The operands and the modulus are `WIDTH` bits wide (256 by default). Each operation takes two passes through an adder. The first pass forms the raw sum or difference in `WIDTH+1` bits, so the carry or borrow is kept. The second pass forms a trial value that is the raw value minus `p` (for addition) or plus `p` (for subtraction). A single high-order bit then picks either the raw value or the trial value. No magnitude comparison against `p` takes place. All values are plain two's-complement binary, so nothing is converted on the way in or out.

The inputs `op_a`, `op_b`, `modulus` and `op_sel` are sampled when `in_valid` is high. The reduced result appears on `sum_q`, and `out_valid` rises one clock later. Between accepted operations the output register keeps its last value. The operands must already be reduced, meaning both are below `modulus`.

Top module: `modadd_unit`

## Requirements
- R1: With `op_sel`=0 (add) and a+b < p, the result one cycle after `in_valid` equals a+b.
- R2: With `op_sel`=0 (add) and a+b ≥ p, the result equals a+b−p. This includes sums that carry out of `WIDTH` bits and the case a+b = p, which gives 0.
- R3: With `op_sel`=1 (subtract) and a ≥ b, the result equals a−b. In particular, a = b gives 0.
- R4: With `op_sel`=1 (subtract) and a < b, the result equals a−b+p.
- R5: The encoding of `op_sel` is 0 for modular addition and 1 for modular subtraction.
- R6: `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R7: When `in_valid` is low at a rising edge, `sum_q` keeps its value, whatever the other inputs do.
- R8: While `rst_n` is low, `out_valid` is 0 and `sum_q` is 0.
- R9: For reduced operands, every valid result is below the modulus that was sampled with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the inputs as a request to capture |
| op_sel | input | 1 | 0 = add, 1 = subtract |
| op_a | input | WIDTH | First operand, below `modulus` |
| op_b | input | WIDTH | Second operand, below `modulus` |
| modulus | input | WIDTH | Prime modulus p |
| sum_q | output | WIDTH | Registered reduced result |
| out_valid | output | 1 | High for one cycle per accepted request |

## Verification
The range and value properties assume that every accepted request carries operands below its modulus. The properties also assume a modulus of at least 2. If either assumption fails, one correction step cannot bring the result back into range. Every stimulus vector and every directed case is built from values such as p−1, 0, equal pairs, or small numbers under a small prime, so each request stays inside these limits. Inputs change freely only while `in_valid` is low, which is where the hold property is exercised.

// File: rtl/modadd_pkg.sv
package modadd_pkg;
   typedef enum logic {
      MA_ADD = 1'b0,
      MA_SUB = 1'b1
   } modadd_op_e;
endpackage

// File: rtl/modadd_raw.sv
// First pass: raw sum or two's-complement difference, one extra bit wide.
module modadd_raw #(
   parameter int WIDTH = 256
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH:0]   raw
);
   localparam int XW = WIDTH + 1;

   logic [XW-1:0] a_x;
   logic [XW-1:0] b_x;
   logic [XW-1:0] b_mux;
   logic [XW-1:0] cin;

   always_comb begin
      a_x   = {1'b0, a};
      b_x   = {1'b0, b};
      b_mux = sub ? ~b_x : b_x;
      cin   = {{(XW-1){1'b0}}, sub};
      raw   = a_x + b_mux + cin;
   end
endmodule

// File: rtl/modadd_fix.sv
// Second pass: trial correction by -p or +p, chosen by one high-order bit.
module modadd_fix #(
   parameter int WIDTH      = 256,
   parameter bit SHARE_CORR = 1'b1
) (
   input  logic [WIDTH:0]   raw,
   input  logic [WIDTH-1:0] p,
   input  logic             sub,
   output logic [WIDTH-1:0] res
);
   localparam int XW = WIDTH + 1;

   logic [XW-1:0] p_x;
   logic [XW-1:0] trial;
   logic          take_trial;

   assign p_x = {1'b0, p};

   generate
      if (SHARE_CORR) begin : g_shared
         // One adder; the addend and the carry-in are muxed by the operation.
         logic [XW-1:0] addend;
         logic [XW-1:0] cin;
         always_comb begin
            addend = sub ? p_x : ~p_x;
            cin    = {{(XW-1){1'b0}}, ~sub};
            trial  = raw + addend + cin;
         end
      end else begin : g_split
         // Two adders in parallel; only the result is muxed.
         logic [XW-1:0] t_dn;
         logic [XW-1:0] t_up;
         always_comb begin
            t_dn  = raw + ~p_x + {{(XW-1){1'b0}}, 1'b1};
            t_up  = raw + p_x;
            trial = sub ? t_up : t_dn;
         end
      end
   endgenerate

   // Add: the trial value is non-negative exactly when raw >= p.
   // Sub: a set top bit of raw marks a borrow, so p must be added back.
   assign take_trial = sub ? raw[WIDTH] : ~trial[WIDTH];
   assign res        = take_trial ? trial[WIDTH-1:0] : raw[WIDTH-1:0];
endmodule

// File: rtl/modadd_unit.sv
module modadd_unit #(
   parameter int WIDTH      = 256,
   parameter bit SHARE_CORR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             op_sel,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] modulus,
   output logic [WIDTH-1:0] sum_q,
   output logic             out_valid
);
   import modadd_pkg::*;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("modadd_unit: WIDTH must be at least 2");
      end
   endgenerate

   modadd_op_e       op;
   logic [WIDTH:0]   raw;
   logic [WIDTH-1:0] res;

   assign op = modadd_op_e'(op_sel);

   modadd_raw #(.WIDTH(WIDTH)) i_raw (
      .a   (op_a),
      .b   (op_b),
      .sub (op == MA_SUB),
      .raw (raw)
   );

   modadd_fix #(.WIDTH(WIDTH), .SHARE_CORR(SHARE_CORR)) i_fix (
      .raw (raw),
      .p   (modulus),
      .sub (op == MA_SUB),
      .res (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) sum_q <= res;
      end
   end
endmodule

// File: rtl/modadd_chk.sv
module modadd_chk #(
   parameter int WIDTH = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             op_sel,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [WIDTH-1:0] modulus,
   input logic [WIDTH-1:0] sum_q,
   input logic             out_valid
);
   logic [WIDTH:0] sum_x;
   logic           small_add;
   assign sum_x     = {1'b0, op_a} + {1'b0, op_b};
   assign small_add = in_valid && !op_sel && (sum_x < {1'b0, modulus});

   p_valid_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(sum_q));

   p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sum_q < $past(modulus)));

   p_sub_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && op_sel && (op_a == op_b)) |-> (sum_q == '0));

   p_add_small_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(small_add) |-> (sum_q == $past(sum_x[WIDTH-1:0])));

   p_reset_r8: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && (sum_q == '0)));
endmodule

bind modadd_unit modadd_chk #(.WIDTH(WIDTH)) i_modadd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .op_a      (op_a),
   .op_b      (op_b),
   .modulus   (modulus),
   .sum_q     (sum_q),
   .out_valid (out_valid)
);

// File: tb/test_modadd_unit.sv
module test_modadd_unit;
   localparam int W  = 256;
   localparam int NV = 12;
   localparam logic [W-1:0] PB = ~256'd0 - 256'd188;
   localparam logic [W-1:0] P7 = 256'd7;

   localparam logic [W-1:0] VA [NV] = '{
      256'd5, 256'd5, 256'd4, 256'd1, 256'd3, PB - 256'd1,
      256'd100, 256'd0, 256'd0, PB - 256'd1, 256'd12345, PB - 256'd1};
   localparam logic [W-1:0] VB [NV] = '{
      256'd4, 256'd4, 256'd5, 256'd2, 256'd4, PB - 256'd1,
      256'd100, PB - 256'd1, 256'd0, 256'd1, PB - 256'd1, 256'd7};
   localparam logic [W-1:0] VP [NV] = '{
      P7, P7, P7, P7, P7, PB, PB, PB, PB, PB, PB, PB};
   localparam logic VOP [NV] = '{
      1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
      1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         op_sel = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] modulus = '0;
   logic [W-1:0] sum_q;
   logic         out_valid;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   modadd_unit #(.WIDTH(W)) i_modadd_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .op_a(op_a), .op_b(op_b), .modulus(modulus),
      .sum_q(sum_q), .out_valid(out_valid));

   function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                          logic [W-1:0] p, logic sub);
      logic [W+1:0] s;
      if (!sub) begin
         s = {2'b00, a} + {2'b00, b};
         if (s >= {2'b00, p}) s = s - {2'b00, p};
      end else if (a >= b) begin
         s = {2'b00, a} - {2'b00, b};
      end else begin
         s = {2'b00, a} + {2'b00, p} - {2'b00, b};
      end
      return s[W-1:0];
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] p, logic sub);
      @(negedge clk);
      op_a = a; op_b = b; modulus = p; op_sel = sub; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      chk("R8 reset result", sum_q, '0);
      chk("R8 reset valid", {255'd0, out_valid}, '0);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R9 R6
      for (int i = 0; i < NV; i++) begin
         issue(VA[i], VB[i], VP[i], VOP[i]);
         chk(VOP[i] ? "R3/R4/R5 sub" : "R1/R2/R5 add", sum_q,
             model(VA[i], VB[i], VP[i], VOP[i]));
         chk("R6 valid one cycle", {255'd0, out_valid}, 256'd1);
         chk("R9 in range", {255'd0, sum_q < VP[i]}, 256'd1);
      end

      // Directed corner cases
      issue(256'd3, 256'd4, P7, 1'b0);
      chk("R2 a+b equals p", sum_q, '0);
      issue(PB - 256'd1, PB - 256'd1, PB, 1'b0);
      chk("R2 carry beyond width", sum_q, PB - 256'd2);
      issue(256'd9, 256'd9, PB, 1'b1);
      chk("R3 a equals b", sum_q, '0);
      issue(256'd0, 256'd1, PB, 1'b1);
      chk("R4 zero minus one", sum_q, PB - 256'd1);
      issue(256'd2, 256'd3, P7, 1'b0);
      chk("R1 small add", sum_q, 256'd5);
      issue(256'd2, 256'd3, P7, 1'b1);
      chk("R5 same operands, sub", sum_q, 256'd6);

      // R7: inputs move while in_valid is low
      held = sum_q;
      @(negedge clk);
      chk("R6 valid drops", {255'd0, out_valid}, '0);
      op_a = 256'd1; op_b = 256'd1; modulus = P7; op_sel = 1'b0;
      repeat (2) @(negedge clk);
      chk("R7 hold while idle", sum_q, held);

      // R8: reset during activity
      issue(256'd1, 256'd1, P7, 1'b0);
      rst_n = 1'b0;
      #1;
      chk("R8 async reset result", sum_q, '0);
      chk("R8 async reset valid", {255'd0, out_valid}, '0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule